// File: doc/BRIEF.md
# PHY Discovery and Link-Wait Sequencer

This block brings up an Ethernet PHY with no help from software. A pulse on `go` starts it. It then works through a management-bus master, one read at a time, over a start/done handshake. First it scans the management addresses in ascending order until one answers. It reads that PHY's two identifier halves and checks the joined 32-bit identifier against a small table of known values set by a parameter. If no address answers, the whole scan is repeated after a fixed pause, up to a set number of passes.

Once a PHY is held, the block polls it for link. Each round reads the control register, which tells whether auto-negotiation is enabled. It then reads the status register and tests it against the mask that follows from that setting. When the mask is not met, the block waits a short pause and starts the next round. The outcome is one of three exclusive flags: link up, no PHY found, or link timeout. The found address and identifier stay visible on their own outputs. All pauses are counted in microsecond ticks that are derived from a clock-frequency parameter.

States and transitions:
- `ST_IDLE` goes to `ST_SCAN_REQ` on `go`, or to `ST_CTRL_REQ` when a PHY is already held.
- `ST_SCAN_REQ` goes to `ST_SCAN_WAIT`.
- `ST_SCAN_WAIT` handles the reply to an ID-high read:
  - any reply other than 0xFFFF goes to `ST_ID2_REQ`;
  - 0xFFFF goes back to `ST_SCAN_REQ` for the next address;
  - 0xFFFF at address 31 goes to `ST_PASS_GAP`, or on the last pass goes to `ST_IDLE` with the no-PHY error.
- `ST_PASS_GAP` goes to `ST_SCAN_REQ` when its timer expires.
- `ST_ID2_REQ` goes to `ST_ID2_WAIT`, then to `ST_CTRL_REQ` on done.
- `ST_CTRL_REQ` goes to `ST_CTRL_WAIT`, then to `ST_STAT_REQ` on done.
- `ST_STAT_REQ` goes to `ST_STAT_WAIT`, which handles the status reply:
  - the mask is met: `ST_IDLE` with link up;
  - the last poll fails: `ST_IDLE` with the link timeout;
  - any other failed poll: `ST_POLL_GAP`.
- `ST_POLL_GAP` goes to `ST_CTRL_REQ` when its timer expires.

Top module: `phy_probe_seq`

## Requirements
- R1: Discovery reads management register 2 (ID high) at addresses 0, 1, 2 … 31, in ascending order, and skips every address whose reply is 0xFFFF.
- R2: The first address whose register-2 reply is not 0xFFFF becomes `phy_addr`. No further register-2 read is made after it.
- R3: Register 3 (ID low) is then read at that same address. `phy_id` equals the ID-high reply in bits 31:16 and the ID-low reply in bits 15:0.
- R4: `id_known` is 1 when `phy_id` equals a table entry that stands before the first zero entry. It is 0 otherwise, and the PHY is used in either case.
- R5: A pass is a full scan of addresses 0 to 31. At most MAX_PASSES passes are made. Before every pass after the first there is a pause of PASS_GAP_US microsecond ticks.
- R6: When every pass fails, `err_no_phy` is set and no link-wait read is made.
- R7: A `go` after a PHY has been identified makes no identifier reads. The sequence starts at the link wait with the stored address.
- R8: Each poll round first reads register 0 (control). If its bit 12 (auto-negotiation enable) is 1, the required mask is bit 5 (auto-negotiation complete) plus bit 2 (link). Otherwise the mask is bit 2 alone.
- R9: Each round then reads register 1 (status). When every bit of the mask is set, `link_up` is set. Otherwise a pause of POLL_GAP_US ticks follows and the round repeats from the control read.
- R10: When MAX_POLLS status reads have failed, `err_link_timeout` is set and polling stops.
- R11: Only one request is outstanding at a time. `mdio_start` is a one-cycle pulse and is not repeated until `mdio_done` has returned. Every request is a read (`mdio_write` = 0).
- R12: `busy` is high from the cycle after `go` until the result. At most one result flag is high, and result flags appear only while `busy` is low. They hold until the next `go`, and a `go` while busy is ignored.
- R13: After reset, `busy`, `mdio_start`, all result flags, `phy_addr` and `phy_id` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start pulse |
| busy | output | 1 | Sequence in progress |
| mdio_start | output | 1 | Request pulse to the management master |
| mdio_write | output | 1 | Request direction, 1 = write (always 0) |
| mdio_phy | output | 5 | Management address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_wdata | output | 16 | Write data (unused, 0) |
| mdio_done | input | 1 | Request complete, one cycle |
| mdio_rdata | input | 16 | Read reply, valid with `mdio_done` |
| phy_addr | output | 5 | Address of the identified PHY |
| phy_id | output | 32 | Identifier of the identified PHY |
| id_known | output | 1 | Identifier found in the known table |
| link_up | output | 1 | Link conditions met |
| err_no_phy | output | 1 | No address answered in any pass |
| err_link_timeout | output | 1 | Poll limit reached without link |

## Verification
Some rules are checked by assertions on every cycle:
- the single-cycle request pulse, and the rule that all requests are reads;
- the ordering of requests: an ID-low read must follow an ID-high read at the same address, and a status read must follow a control read;
- the bounds on the pass and poll counters;
- the exclusive result flags, which may appear only while the block is idle.

Other behaviour can be shown only by the bench's scenarios:
- the first responding address among 32, swept one by one;
- the joining of the two identifier halves, and table lookups that include an entry after the zero terminator;
- the late appearance of a PHY in a second pass, and the length of the pause between passes;
- the mask selection under both auto-negotiation settings;
- the timeout count, and the skip of discovery on a repeated `go`.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN_REQ,
        ST_SCAN_WAIT,
        ST_PASS_GAP,
        ST_ID2_REQ,
        ST_ID2_WAIT,
        ST_CTRL_REQ,
        ST_CTRL_WAIT,
        ST_STAT_REQ,
        ST_STAT_WAIT,
        ST_POLL_GAP
    } seq_state_e;

    localparam logic [4:0]  REG_CTRL    = 5'd0;
    localparam logic [4:0]  REG_STAT    = 5'd1;
    localparam logic [4:0]  REG_ID_HI   = 5'd2;
    localparam logic [4:0]  REG_ID_LO   = 5'd3;
    localparam logic [4:0]  LAST_ADDR   = 5'd31;
    localparam int          BIT_AN_EN   = 12;
    localparam int          BIT_AN_DONE = 5;
    localparam int          BIT_LINK    = 2;
    localparam logic [15:0] NO_REPLY    = 16'hFFFF;

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            logic [W-1:0] cnt_q;
            assign tick = (cnt_q == W'(DIV - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    cnt_q <= '0;
                else if (tick) cnt_q <= '0;
                else           cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/us_timer.sv
module us_timer #(
    parameter int MAX_US = 10000,
    localparam int W     = $clog2(MAX_US + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = tick && (cnt_q == W'(1)) && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/id_matcher.sv
module id_matcher #(
    parameter int                      NUM_IDS = 4,
    parameter logic [NUM_IDS*32-1:0]   TABLE   = '0
) (
    input  logic [31:0] id,
    output logic        hit
);
    logic [NUM_IDS-1:0] live;
    logic [NUM_IDS-1:0] match;

    generate
        for (genvar i = 0; i < NUM_IDS; i++) begin : g_entry
            localparam logic [31:0] ENTRY = TABLE[i*32 +: 32];
            if (i == 0) begin : g_first
                assign live[i] = (ENTRY != 32'd0);
            end else begin : g_next
                assign live[i] = live[i-1] && (ENTRY != 32'd0);
            end
            assign match[i] = live[i] && (id == ENTRY);
        end
    endgenerate

    assign hit = |match;
endmodule

// File: rtl/phy_probe_seq.sv
module phy_probe_seq
    import phy_probe_pkg::*;
#(
    parameter int                    CLK_HZ      = 50_000_000,
    parameter int                    MAX_PASSES  = 11,
    parameter int                    PASS_GAP_US = 10000,
    parameter int                    POLL_GAP_US = 1,
    parameter int                    MAX_POLLS   = 1000,
    parameter int                    NUM_IDS     = 4,
    parameter logic [NUM_IDS*32-1:0] KNOWN_IDS   = {32'h0,
                                                    32'h0E11_7A40,
                                                    32'h0C3D_1160,
                                                    32'h0B52_9A10}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    output logic        busy,
    output logic        mdio_start,
    output logic        mdio_write,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_done,
    input  logic [15:0] mdio_rdata,
    output logic [4:0]  phy_addr,
    output logic [31:0] phy_id,
    output logic        id_known,
    output logic        link_up,
    output logic        err_no_phy,
    output logic        err_link_timeout
);
    localparam int TICK_DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int GAP_MAX  = (PASS_GAP_US > POLL_GAP_US) ? PASS_GAP_US : POLL_GAP_US;
    localparam int TW       = $clog2(GAP_MAX + 1);
    localparam int PW       = $clog2(MAX_PASSES + 1);
    localparam int QW       = $clog2(MAX_POLLS + 1);

    seq_state_e state_q, state_d;

    logic [4:0]    scan_addr_q;
    logic [PW-1:0] pass_cnt_q;
    logic [QW-1:0] poll_cnt_q;
    logic [15:0]   id_hi_q;
    logic [4:0]    phy_addr_q;
    logic [31:0]   phy_id_q;
    logic          have_phy_q;
    logic          an_en_q;
    logic          link_up_q, err_np_q, err_lt_q;

    logic          tick, expire, timer_load, match_hit;
    logic [TW-1:0] timer_val;

    logic no_reply, last_addr, last_pass, last_poll, link_ok;
    assign no_reply  = (mdio_rdata == NO_REPLY);
    assign last_addr = (scan_addr_q == LAST_ADDR);
    assign last_pass = (pass_cnt_q >= PW'(MAX_PASSES));
    assign last_poll = (poll_cnt_q >= QW'(MAX_POLLS - 1));
    assign link_ok   = mdio_rdata[BIT_LINK] && (!an_en_q || mdio_rdata[BIT_AN_DONE]);

    us_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    us_timer #(.MAX_US(GAP_MAX)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .tick     (tick),
        .expire   (expire)
    );

    id_matcher #(.NUM_IDS(NUM_IDS), .TABLE(KNOWN_IDS)) match_i (
        .id  (phy_id_q),
        .hit (match_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go) state_d = have_phy_q ? ST_CTRL_REQ : ST_SCAN_REQ;
            ST_SCAN_REQ:  state_d = ST_SCAN_WAIT;
            ST_SCAN_WAIT: if (mdio_done) begin
                              if (!no_reply)      state_d = ST_ID2_REQ;
                              else if (!last_addr) state_d = ST_SCAN_REQ;
                              else if (last_pass)  state_d = ST_IDLE;
                              else                 state_d = ST_PASS_GAP;
                          end
            ST_PASS_GAP:  if (expire) state_d = ST_SCAN_REQ;
            ST_ID2_REQ:   state_d = ST_ID2_WAIT;
            ST_ID2_WAIT:  if (mdio_done) state_d = ST_CTRL_REQ;
            ST_CTRL_REQ:  state_d = ST_CTRL_WAIT;
            ST_CTRL_WAIT: if (mdio_done) state_d = ST_STAT_REQ;
            ST_STAT_REQ:  state_d = ST_STAT_WAIT;
            ST_STAT_WAIT: if (mdio_done) state_d = (link_ok || last_poll) ? ST_IDLE : ST_POLL_GAP;
            ST_POLL_GAP:  if (expire) state_d = ST_CTRL_REQ;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mdio_start = 1'b0;
        mdio_reg   = REG_CTRL;
        mdio_phy   = phy_addr_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_SCAN_REQ: begin mdio_start = 1'b1; mdio_reg = REG_ID_HI; mdio_phy = scan_addr_q; end
            ST_SCAN_WAIT: begin
                mdio_reg = REG_ID_HI;
                mdio_phy = scan_addr_q;
                if (mdio_done && no_reply && last_addr && !last_pass) begin
                    timer_load = 1'b1;
                    timer_val  = TW'(PASS_GAP_US);
                end
            end
            ST_ID2_REQ:   begin mdio_start = 1'b1; mdio_reg = REG_ID_LO; end
            ST_ID2_WAIT:  mdio_reg = REG_ID_LO;
            ST_CTRL_REQ:  mdio_start = 1'b1;
            ST_STAT_REQ:  begin mdio_start = 1'b1; mdio_reg = REG_STAT; end
            ST_STAT_WAIT: begin
                mdio_reg = REG_STAT;
                if (mdio_done && !link_ok && !last_poll) begin
                    timer_load = 1'b1;
                    timer_val  = TW'(POLL_GAP_US);
                end
            end
            default: ;
        endcase
    end

    assign mdio_write       = 1'b0;
    assign mdio_wdata       = '0;
    assign busy             = (state_q != ST_IDLE);
    assign phy_addr         = phy_addr_q;
    assign phy_id           = phy_id_q;
    assign id_known         = have_phy_q && match_hit;
    assign link_up          = link_up_q;
    assign err_no_phy       = err_np_q;
    assign err_link_timeout = err_lt_q;

    // Sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_addr_q <= '0;
            pass_cnt_q  <= '0;
            poll_cnt_q  <= '0;
            id_hi_q     <= '0;
            phy_addr_q  <= '0;
            phy_id_q    <= '0;
            have_phy_q  <= 1'b0;
            an_en_q     <= 1'b0;
            link_up_q   <= 1'b0;
            err_np_q    <= 1'b0;
            err_lt_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    link_up_q   <= 1'b0;
                    err_np_q    <= 1'b0;
                    err_lt_q    <= 1'b0;
                    poll_cnt_q  <= '0;
                    scan_addr_q <= '0;
                    pass_cnt_q  <= PW'(1);
                end
                ST_SCAN_WAIT: if (mdio_done) begin
                    if (!no_reply) begin
                        phy_addr_q <= scan_addr_q;
                        id_hi_q    <= mdio_rdata;
                    end else if (!last_addr) begin
                        scan_addr_q <= scan_addr_q + 1'b1;
                    end else if (last_pass) begin
                        err_np_q <= 1'b1;
                    end
                end
                ST_PASS_GAP: if (expire) begin
                    pass_cnt_q  <= pass_cnt_q + 1'b1;
                    scan_addr_q <= '0;
                end
                ST_ID2_WAIT: if (mdio_done) begin
                    phy_id_q   <= {id_hi_q, mdio_rdata};
                    have_phy_q <= 1'b1;
                end
                ST_CTRL_WAIT: if (mdio_done) an_en_q <= mdio_rdata[BIT_AN_EN];
                ST_STAT_WAIT: if (mdio_done) begin
                    if (link_ok)        link_up_q <= 1'b1;
                    else if (last_poll) err_lt_q  <= 1'b1;
                end
                ST_POLL_GAP: if (expire) poll_cnt_q <= poll_cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Assertions
    logic [4:0] prev_reg_q, prev_phy_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_reg_q <= REG_CTRL;
            prev_phy_q <= '0;
        end else if (mdio_start) begin
            prev_reg_q <= mdio_reg;
            prev_phy_q <= mdio_phy;
        end
    end

    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_start |=> !mdio_start);
    a_r11_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_start |-> !mdio_write);
    a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_up, err_no_phy, err_link_timeout}));
    a_r12_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up || err_no_phy || err_link_timeout) |-> !busy);
    a_r5_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pass_cnt_q <= PW'(MAX_PASSES));
    a_r10_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt_q < QW'(MAX_POLLS));
    a_r3_lo_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_start && mdio_reg == REG_ID_LO) |-> (prev_reg_q == REG_ID_HI && prev_phy_q == mdio_phy));
    a_r8_ctrl_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_start && mdio_reg == REG_STAT) |-> prev_reg_q == REG_CTRL);
endmodule

// File: tb/phy_probe_seq_tb_top.sv
module phy_probe_seq_tb_top;
    localparam int CLK_HZ = 4_000_000;
    localparam int DIV    = 4;
    localparam int PASSES = 3;
    localparam int PGAP   = 20;
    localparam int QGAP   = 2;
    localparam int POLLS  = 4;
    localparam int LAT    = 2;
    localparam logic [127:0] TABLE = {32'h0F0F_0003, 32'h0, 32'h5A5A_0002, 32'hA5A5_0001};

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic busy, mdio_start, mdio_write, id_known, link_up, err_no_phy, err_link_timeout;
    logic [4:0] mdio_phy, mdio_reg, phy_addr;
    logic [15:0] mdio_wdata;
    logic [31:0] phy_id;
    logic mdio_done = 1'b0;
    logic [15:0] mdio_rdata = '0;

    always #10 clk = ~clk;

    phy_probe_seq #(
        .CLK_HZ(CLK_HZ), .MAX_PASSES(PASSES), .PASS_GAP_US(PGAP),
        .POLL_GAP_US(QGAP), .MAX_POLLS(POLLS), .NUM_IDS(4), .KNOWN_IDS(TABLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
        .mdio_start(mdio_start), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
        .mdio_rdata(mdio_rdata), .phy_addr(phy_addr), .phy_id(phy_id),
        .id_known(id_known), .link_up(link_up), .err_no_phy(err_no_phy),
        .err_link_timeout(err_link_timeout)
    );

    int checks = 0, errors = 0;

    // PHY model configuration (written by the stimulus only)
    int phy_at = -1, appear_after = 0, good_after = 0;
    logic [15:0] id1_v = '0, id2_v = '0, ctl_v = '0, good_v = '0, bad_v = '0;
    logic clr_req = 1'b1;

    // PHY model state (written by the model only)
    int n_id1, n_id2, n_ctl, n_stat, order_err, overlap_err, write_err, exp_addr, lat_cnt;
    int gap_min, gap_max, n_gaps;
    longint cyc = 0, t_end;
    logic [15:0] resp;

    function automatic logic [15:0] model_val(logic [4:0] a, logic [4:0] r);
        case (r)
            5'd2:    return (phy_at == int'(a) && n_id1 >= appear_after) ? id1_v : 16'hFFFF;
            5'd3:    return (phy_at == int'(a)) ? id2_v : 16'hFFFF;
            5'd0:    return ctl_v;
            5'd1:    return (n_stat >= good_after) ? good_v : bad_v;
            default: return 16'hFFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_req) begin
            n_id1 <= 0; n_id2 <= 0; n_ctl <= 0; n_stat <= 0;
            order_err <= 0; overlap_err <= 0; write_err <= 0; exp_addr <= 0;
            lat_cnt <= 0; gap_min <= 1000000; gap_max <= 0; n_gaps <= 0; t_end <= -1;
            mdio_done <= 1'b0;
        end else begin
            mdio_done <= 1'b0;
            if (lat_cnt == 1) begin mdio_done <= 1'b1; mdio_rdata <= resp; end
            if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
            if (mdio_start) begin
                if (lat_cnt != 0) overlap_err <= overlap_err + 1;
                if (mdio_write) write_err <= write_err + 1;
                lat_cnt <= LAT;
                resp <= model_val(mdio_phy, mdio_reg);
                case (mdio_reg)
                    5'd2: begin
                        n_id1 <= n_id1 + 1;
                        if (int'(mdio_phy) != exp_addr) order_err <= order_err + 1;
                        exp_addr <= (int'(mdio_phy) + 1) % 32;
                        if (mdio_phy == 5'd31) t_end <= cyc;
                        if (mdio_phy == 5'd0 && t_end >= 0) begin
                            n_gaps <= n_gaps + 1;
                            if (int'(cyc - t_end) < gap_min) gap_min <= int'(cyc - t_end);
                            if (int'(cyc - t_end) > gap_max) gap_max <= int'(cyc - t_end);
                        end
                    end
                    5'd3: n_id2 <= n_id2 + 1;
                    5'd0: n_ctl <= n_ctl + 1;
                    5'd1: n_stat <= n_stat + 1;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clr_req = 1'b1; go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; clr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_counts();
        clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    endtask

    task automatic set_phy(int at, logic [15:0] i1, logic [15:0] i2, bit an, int ga);
        phy_at = at; id1_v = i1; id2_v = i2; good_after = ga; appear_after = 0;
        ctl_v  = an ? 16'h1000 : 16'h0000;
        good_v = an ? 16'h0024 : 16'h0004;
        bad_v  = an ? 16'h0004 : 16'h0020;
    endtask

    task automatic run_go(bit poke);
        int k = 0;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        chk("R12", "busy after go", busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            go = 1'b1; @(negedge clk); go = 1'b0;
        end
        while (busy && k < 20000) begin @(negedge clk); k++; end
        chk("R12", "busy cleared", busy, 0);
    endtask

    initial begin
        @(negedge clk);
        while (cyc < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R13 reset state
        chk("R13", "busy", busy, 0);
        chk("R13", "mdio_start", mdio_start, 0);
        chk("R13", "flags", {link_up, err_no_phy, err_link_timeout}, 0);
        chk("R13", "phy_addr", phy_addr, 0);
        chk("R13", "phy_id", phy_id, 0);

        // Sweep: PHY at every address, both auto-negotiation settings, varied polls
        for (int a = 0; a < 32; a++) begin
            logic [15:0] i1, i2;
            bit known, an;
            int ga;
            i1 = 16'h1000 + 16'(a); i2 = 16'h2000 + 16'(a * 3);
            if (a == 7)  begin i1 = 16'hA5A5; i2 = 16'h0001; end
            if (a == 20) begin i1 = 16'h5A5A; i2 = 16'h0002; end
            if (a == 12) begin i1 = 16'h0F0F; i2 = 16'h0003; end
            known = (a == 7 || a == 20);
            an = a[0];
            ga = a % 3;
            do_reset();
            set_phy(a, i1, i2, an, ga);
            run_go(a == 9);
            chk("R1", "ID-high reads", n_id1, a + 1);
            chk("R1", "scan order", order_err, 0);
            chk("R2", "phy_addr", phy_addr, a);
            chk("R3", "ID-low reads", n_id2, 1);
            chk("R3", "phy_id", phy_id, {i1, i2});
            chk("R4", "id_known", id_known, known);
            chk("R8", "control reads", n_ctl, ga + 1);
            chk("R9", "status reads", n_stat, ga + 1);
            chk("R9", "link_up", link_up, 1);
            chk("R12", "errors clear", {err_no_phy, err_link_timeout}, 0);
            chk("R11", "overlap/write", overlap_err + write_err, 0);
        end

        // R7: second go reuses stored PHY (address 31 from last sweep run)
        clear_counts();
        set_phy(31, 16'h1000 + 16'd31, 16'h2000 + 16'd93, 1'b0, 0);
        run_go(1'b0);
        chk("R7", "no ID-high reads", n_id1, 0);
        chk("R7", "no ID-low reads", n_id2, 0);
        chk("R7", "control reads", n_ctl, 1);
        chk("R7", "phy_addr kept", phy_addr, 31);
        chk("R7", "link_up", link_up, 1);

        // R6/R5: no PHY at all
        do_reset();
        set_phy(-1, 16'h0, 16'h0, 1'b1, 0);
        run_go(1'b0);
        chk("R6", "err_no_phy", err_no_phy, 1);
        chk("R6", "no link reads", n_ctl + n_stat, 0);
        chk("R6", "link_up", link_up, 0);
        chk("R5", "ID-high reads", n_id1, 32 * PASSES);
        chk("R5", "gaps", n_gaps, PASSES - 1);
        chk("R5", "gap min in window", (gap_min >= (PGAP - 1) * DIV) ? 1 : 0, 1);
        chk("R5", "gap max in window", (gap_max <= PGAP * DIV + 8) ? 1 : 0, 1);
        chk("R1", "scan order", order_err, 0);
        chk("R4", "id_known no phy", id_known, 0);

        // R5: PHY appears during the second pass
        do_reset();
        set_phy(8, 16'h0F0F, 16'h0003, 1'b1, 0);
        appear_after = 40;
        run_go(1'b1);
        chk("R5", "ID-high reads", n_id1, 41);
        chk("R5", "gaps", n_gaps, 1);
        chk("R2", "phy_addr", phy_addr, 8);
        chk("R4", "entry after terminator", id_known, 0);
        chk("R12", "go while busy ignored", link_up, 1);

        // R10: link never comes (AN on, only link bit set)
        do_reset();
        set_phy(3, 16'h5A5A, 16'h0002, 1'b1, 1000);
        run_go(1'b0);
        chk("R10", "err_link_timeout", err_link_timeout, 1);
        chk("R10", "status reads", n_stat, POLLS);
        chk("R10", "control reads", n_ctl, POLLS);
        chk("R10", "link_up", link_up, 0);
        chk("R4", "known id", id_known, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule